// File: doc/BRIEF.md
# Modem Status and Control Register Block

This block sits beside a UART's interrupt logic and owns the two modem-facing registers. It brings four modem input lines (clear-to-send, data-set-ready, carrier-detect and ring) through a synchroniser and keeps their levels in the upper half of an 8-bit status value. It records every change in the lower half as sticky delta flags. A pulse on the read strobe returns the status value and then clears the flags. While any flag is set, a change indication goes to the interrupt controller.

The block also holds a 5-bit control register that drives the modem output lines and a loopback switch. With loopback on, the status value seen on the read port is built from the control outputs rather than the pins, and its delta half reads as zero. The stored status register keeps tracking the real pins underneath.

Top module: `mstat_ctrl`

## Requirements
- R1: The status read value carries the synchronised pin levels at bit 7 (carrier detect), bit 6 (ring), bit 5 (data set ready) and bit 4 (clear to send). A pin change shows there SYNC_STAGES+1 clock edges after it is applied.
- R2: Any change in clear-to-send, data-set-ready or carrier-detect sets delta bit 0, 1 or 3 respectively. The bit stays set through further changes until it is cleared by a read.
- R3: Delta bit 2 (trailing ring edge) is set only when the ring level falls from 1 to 0. A rise of the ring level leaves it unchanged.
- R4: While loopback is off, the read value is present on the read port in the same cycle as the read strobe. The clock edge that ends the strobe clears bits 3:0. A delta event that is taken at that same edge stays set.
- R5: msc_irq is high exactly when at least one stored delta bit is set.
- R6: A write strobe loads wdata[4:0] into the control register: bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loopback. Bits 7:5 are dropped, and the register holds its value between writes.
- R7: After reset the control register reads 0x08 (OUT2 only), and the initial pin levels produce no delta bits and no change indication.
- R8: With loopback on, the read value has OUT2 in bit 7, OUT1 in bit 6, DTR in bit 5, RTS in bit 4 and zeros in bits 3:0.
- R9: With loopback on, pin changes still accumulate in the stored deltas and drive msc_irq, and a read does not clear them. They become visible once loopback is turned off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_stb | input | 1 | Status register read strobe, one cycle |
| wr_stb | input | 1 | Control register write strobe, one cycle |
| wdata | input | 8 | Write data for the control register |
| cts_i | input | 1 | Clear-to-send pin, asynchronous |
| dsr_i | input | 1 | Data-set-ready pin, asynchronous |
| dcd_i | input | 1 | Carrier-detect pin, asynchronous |
| ri_i | input | 1 | Ring pin, asynchronous |
| stat_rdata | output | 8 | Status read value |
| ctl_o | output | 5 | Control register (DTR, RTS, OUT1, OUT2, loopback) |
| msc_irq | output | 1 | Modem status change indication |

## Verification
A stale stored level makes the next genuine pin change either miss its delta bit or raise a spurious one. This shows on stat_rdata and msc_irq SYNC_STAGES+1 edges after that pin change. A delta that fails to clear keeps msc_irq high on the cycle right after a read. A clear that wipes an event taken at the same edge loses the interrupt for good. Those coincident edges and ring rises against falls are driven on purpose, and a random walk of pin levels with reads in between is compared with a bench model.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
   // control register bit positions (decoded by the loopback mapping)
   localparam int CTL_W     = 5;
   localparam int CB_DTR    = 0;
   localparam int CB_RTS    = 1;
   localparam int CB_OUT1   = 2;
   localparam int CB_OUT2   = 3;
   localparam int CB_LOOP   = 4;
   // status nibble order: {carrier, ring, set-ready, clear-to-send}
   localparam int LINES     = 4;
   localparam int LB_CTS    = 0;
   localparam int LB_DSR    = 1;
   localparam int LB_RI     = 2;
   localparam int LB_DCD    = 3;

   function automatic logic [LINES-1:0] loop_lines(input logic [CTL_W-1:0] c);
      return {c[CB_OUT2], c[CB_OUT1], c[CB_DTR], c[CB_RTS]};
   endfunction
endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mstat_delta.sv
module mstat_delta
   import mstat_pkg::*;
#(
   parameter int SETTLE = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] smp,
   input  logic             clr,
   output logic [7:0]       stat
);
   localparam int CW = $clog2(SETTLE + 1);

   logic [LINES-1:0] lvl_q, dlt_q, chg, ev;
   logic [CW-1:0]    cnt_q;
   logic             primed_q;

   assign chg = smp ^ lvl_q;

   always_comb begin
      ev         = chg;
      ev[LB_RI]  = lvl_q[LB_RI] & ~smp[LB_RI];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q    <= '0;
         dlt_q    <= '0;
         cnt_q    <= '0;
         primed_q <= 1'b0;
      end else if (!primed_q) begin
         if (cnt_q == CW'(SETTLE)) begin
            lvl_q    <= smp;
            primed_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else begin
         lvl_q <= smp;
         dlt_q <= (clr ? '0 : dlt_q) | ev;
      end
   end

   assign stat = {lvl_q, dlt_q};
endmodule

// File: rtl/mstat_ctl.sv
module mstat_ctl
   import mstat_pkg::*;
#(
   parameter logic [CTL_W-1:0] RST_VAL = 5'b01000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [7:0]       wdata,
   output logic [CTL_W-1:0] ctl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctl <= RST_VAL;
      else if (wr) ctl <= wdata[CTL_W-1:0];
   end
endmodule

// File: rtl/mstat_ctrl.sv
module mstat_ctrl
   import mstat_pkg::*;
#(
   parameter int               SYNC_STAGES = 2,
   parameter logic [CTL_W-1:0] CTL_RST     = 5'b01000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_stb,
   input  logic             wr_stb,
   input  logic [7:0]       wdata,
   input  logic             cts_i,
   input  logic             dsr_i,
   input  logic             dcd_i,
   input  logic             ri_i,
   output logic [7:0]       stat_rdata,
   output logic [CTL_W-1:0] ctl_o,
   output logic             msc_irq
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("mstat_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [LINES-1:0] w_pins, w_sync;
   logic [7:0]       w_stat;
   logic             w_loop;

   always_comb begin
      w_pins         = '0;
      w_pins[LB_CTS] = cts_i;
      w_pins[LB_DSR] = dsr_i;
      w_pins[LB_RI]  = ri_i;
      w_pins[LB_DCD] = dcd_i;
   end

   mstat_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(w_pins), .q(w_sync)
   );

   mstat_ctl #(.RST_VAL(CTL_RST)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr(wr_stb), .wdata(wdata), .ctl(ctl_o)
   );

   assign w_loop = ctl_o[CB_LOOP];

   mstat_delta #(.SETTLE(SYNC_STAGES)) u_dlt (
      .clk(clk), .rst_n(rst_n), .smp(w_sync),
      .clr(rd_stb & ~w_loop), .stat(w_stat)
   );

   assign stat_rdata = w_loop ? {loop_lines(ctl_o), 4'b0000} : w_stat;
   assign msc_irq    = |w_stat[3:0];
endmodule

// File: rtl/mstat_ctrl_chk.sv
module mstat_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rd_stb,
   input logic       wr_stb,
   input logic [7:0] wdata,
   input logic [4:0] ctl_o,
   input logic [7:0] stat_rdata,
   input logic       msc_irq,
   input logic [3:0] sync_q,
   input logic [7:0] st
);
   a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (msc_irq && !(rd_stb && !ctl_o[4])) |=> msc_irq);

   a_r3_rise_no_teri: assert property (@(posedge clk) disable iff (!rst_n)
      (!st[6] && sync_q[2] && !st[2]) |=> !st[2]);

   a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !ctl_o[4] && sync_q == st[7:4]) |=> st[3:0] == 4'h0);

   a_r6_write_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> ctl_o == $past(wdata[4:0]));

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(ctl_o));

   a_r8_loop_view: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_o[4] |-> stat_rdata == {ctl_o[3], ctl_o[2], ctl_o[0], ctl_o[1], 4'h0});
endmodule

bind mstat_ctrl mstat_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata),
   .ctl_o(ctl_o), .stat_rdata(stat_rdata), .msc_irq(msc_irq),
   .sync_q(w_sync), .st(w_stat)
);

// File: tb/mstat_ctrl_tb.sv
`timescale 1ns/1ps
module mstat_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rd_stb = 1'b0, wr_stb = 1'b0;
   logic [7:0] wdata = '0;
   logic [3:0] pv = 4'b1011;  // {dcd, ri, dsr, cts}
   logic [7:0] stat_rdata;
   logic [4:0] ctl_o;
   logic       msc_irq;
   int         n_run = 0, n_fail = 0;
   logic [3:0] m_lvl, m_dlt;

   always #2.5 clk = ~clk;

   mstat_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata),
      .cts_i(pv[0]), .dsr_i(pv[1]), .dcd_i(pv[3]), .ri_i(pv[2]),
      .stat_rdata(stat_rdata), .ctl_o(ctl_o), .msc_irq(msc_irq)
   );

   function automatic logic [3:0] evts(input logic [3:0] o, input logic [3:0] n);
      return {o[3] ^ n[3], o[2] & ~n[2], o[1] ^ n[1], o[0] ^ n[0]};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_pins(input logic [3:0] v);
      m_dlt = m_dlt | evts(m_lvl, v);
      m_lvl = v;
      pv    = v;
      step(4);
   endtask

   task automatic do_read();
      rd_stb = 1'b1;
      step(1);
      rd_stb = 1'b0;
      m_dlt  = '0;
   endtask

   task automatic wr_ctl(input logic [7:0] v);
      wdata = v; wr_stb = 1'b1;
      step(1);
      wr_stb = 1'b0;
   endtask

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      m_lvl = 4'b1011; m_dlt = '0;
      step(3);
      rst_n = 1'b1;
      step(6);
      // R7: reset state, no deltas from pin levels present at reset
      chk("R7 ctl reset", ctl_o, 5'h08);
      chk("R7 no delta", stat_rdata, 8'hB0);
      chk("R7 irq low", msc_irq, 1'b0);
      // R1: levels shown after sync latency
      pv = 4'b0010;
      step(2);
      chk("R1 not yet", stat_rdata[7:4], 4'hB);
      step(1);
      chk("R1 level", stat_rdata[7:4], 4'h2);
      m_lvl = 4'b0010; m_dlt = evts(4'b1011, 4'b0010);
      chk("R2 delta dcd/cts", stat_rdata[3:0], m_dlt);
      chk("R5 irq set", msc_irq, 1'b1);
      // R4: read value present with strobe, cleared after
      rd_stb = 1'b1;
      chk("R4 value during read", stat_rdata, {m_lvl, m_dlt});
      step(1); rd_stb = 1'b0; m_dlt = '0;
      chk("R4 cleared", stat_rdata[3:0], 4'h0);
      chk("R5 irq clear", msc_irq, 1'b0);
      // R3: ring rise does not set trailing edge, fall does
      set_pins(4'b0110);
      chk("R3 rise no teri", stat_rdata[3:0], 4'h0);
      chk("R5 irq after rise", msc_irq, 1'b0);
      set_pins(4'b0010);
      chk("R3 fall teri", stat_rdata[3:0], 4'b0100);
      do_read();
      // R2: toggle and toggle back stays sticky
      set_pins(4'b0011);
      set_pins(4'b0010);
      chk("R2 sticky", stat_rdata, 8'h21);
      do_read();
      // R4: event taken at the clearing edge survives
      set_pins(4'b0000);              // DSR delta pending
      pv = 4'b0001;                   // CTS change
      step(2);
      rd_stb = 1'b1;
      step(1);
      rd_stb = 1'b0;
      m_lvl = 4'b0001; m_dlt = 4'b0001;
      chk("R4 coincident event kept", stat_rdata, 8'h11);
      do_read();
      // R6: control write masking
      wr_ctl(8'hEF);
      chk("R6 masked write", ctl_o, 5'h0F);
      step(3);
      chk("R6 hold", ctl_o, 5'h0F);
      // R8: loopback mapping
      wr_ctl(8'h1A);
      chk("R8 map out2 rts", stat_rdata, 8'h90);
      wr_ctl(8'h15);
      chk("R8 map out1 dtr", stat_rdata, 8'h60);
      // R9: pins tracked and not cleared in loopback
      set_pins(4'b1001);
      chk("R9 loop hides deltas", stat_rdata, 8'h60);
      chk("R9 irq in loop", msc_irq, 1'b1);
      rd_stb = 1'b1; step(1); rd_stb = 1'b0;
      chk("R9 irq kept after loop read", msc_irq, 1'b1);
      wr_ctl(8'h08);
      chk("R9 deltas after loop", stat_rdata, {m_lvl, m_dlt});
      do_read();
      // random walk
      void'($urandom(32'h5EED));
      for (int i = 0; i < 60; i++) begin
         set_pins(4'($urandom));
         chk("R2 random", stat_rdata, {m_lvl, m_dlt});
         chk("R5 random irq", msc_irq, |m_dlt);
         if ($urandom % 3 == 0) begin
            do_read();
            chk("R4 random clear", stat_rdata[3:0], 4'h0);
         end
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule